// File: doc/BRIEF.md
# SPI Bring-Up Sequencer with Readback Verify

This block is an SPI master that brings up a register-mapped peripheral and then keeps it sending one message. After a start pulse it issues a fixed list of single-word register writes. It then reads back a subset of those registers and checks each returned word against an expected value through a per-entry compare mask. If every readback agrees, it reads a buffer-status register. If that register reports the transmit buffer free, it writes an 18-word payload in one burst, then writes a send request, and goes back to the readback step. The block keeps cycling in this way.

Every transaction opens with a header of four bytes: an opcode, a 16-bit address and a count of 32-bit data words. Data words follow, most significant byte first. The write list, the readback list with its expected values and masks, and the payload all come from constant functions in the package. A saturating counter records failed readback passes. When that counter reaches a parameterised limit, the sequencer raises an error and parks with chip select released.

Top module: `spi_bringup_seq`

## Requirements
- R1: After reset, `cs_n` is 1 and `sclk`, `done`, `error` and `mismatch_cnt` are 0. No transaction begins until a one-cycle `start` pulse is seen.
- R2: The SPI runs in mode 0. `sclk` is low whenever `cs_n` is high. Each SCLK period lasts `CLK_DIV` clocks, with `CLK_DIV/2` of them high. `mosi` holds its value while `sclk` is high. `miso` is sampled on the rising edge. Bits go most significant first.
- R3: Byte 0 of every transaction is the opcode: 0x61 for a write, 0x41 for a read. Bytes 1 and 2 carry the 16-bit address, high byte first. Byte 3 gives the number of 32-bit data words. Data words follow, most significant byte first.
- R4: During a read, the master drives 0xFF on every data byte. The register value is taken from the final four MISO bytes. Whatever the slave returns during the four header bytes has no effect.
- R5: `cs_n` stays low for every byte of a transaction, including all 18 words of the burst. Between two transactions it stays high for at least 2 SCLK periods.
- R6: After `start`, the block writes the ten single-word entries of the package's init table in table order. The first entry writes 0x00000001 to address 0x0800. It then performs the seven readbacks of the check table in table order, the first of which reads address 0x101C.
- R7: A readback passes when `((value ^ expected) & mask) == 0`. Bits whose mask bit is 0 are ignored. The entry for address 0x0800 uses mask 0xFFFFFFF0, and every other entry uses 0xFFFFFFFF.
- R8: If a readback pass contains one or more failing entries, `mismatch_cnt` increases by exactly 1 after the seventh readback, and the pass restarts at the first check entry.
- R9: If all seven entries of a pass succeed, the block reads the status register at 0x10C4. Bit 0 set to 1 means the buffer is ready. If bit 0 is 0, the block returns to the first readback.
- R10: When the buffer is ready, the block writes 18 words (length 0x12) to 0x8800. Word i of the payload is {0x5A, i, ~i, 0xC3}. The block then writes 0x00000001 to 0x10D0 and returns to the readback step. `done` rises when the first send-request write completes and stays high.
- R11: When `mismatch_cnt` reaches `RETRY_LIMIT`, `error` rises at the end of that pass and stays high. No further transaction starts, and `start` is ignored, until reset.
- R12: A `start` pulse that arrives while the sequence is running has no effect on the transaction stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins the bring-up sequence |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low chip select, held for a whole transaction |
| done | output | 1 | Set once the first send request has been written |
| error | output | 1 | Set when the retry limit is reached; the block halts |
| mismatch_cnt | output | $clog2(RETRY_LIMIT+1) | Number of failed readback passes |

## Verification
The bound assertions check the following on every cycle:
- `sclk` stays idle while chip select is released.
- `mosi` holds steady while `sclk` is high.
- Chip select stays high for the minimum gap.
- `mismatch_cnt` only ever steps up by one and never passes the limit.
- `done` and `error` are sticky, and the bus stays silent once halted.

Only the bench's scenarios can show the following:
- The byte content and order of each transaction.
- Masked-out bit differences being tolerated.
- The not-ready poll looping back to readback.
- The burst payload and the send request.
- The exact pass at which the retry limit stops the flow.

They do this by injecting status values and corrupted readbacks from a slave model.

// File: rtl/spi_bringup_pkg.sv
package spi_bringup_pkg;

    localparam logic [7:0]  OPC_WRITE   = 8'h61;
    localparam logic [7:0]  OPC_READ    = 8'h41;
    localparam logic [7:0]  FILL_BYTE   = 8'hFF;

    localparam int          N_INIT      = 10;
    localparam int          N_CHECK     = 7;
    localparam int          N_BURST     = 18;
    localparam int          IDX_W       = 5;

    localparam logic [15:0] ADDR_STATUS = 16'h10C4;
    localparam logic [15:0] ADDR_BURST  = 16'h8800;
    localparam logic [15:0] ADDR_SEND   = 16'h10D0;
    localparam logic [31:0] SEND_WORD   = 32'h0000_0001;
    localparam int          READY_BIT   = 0;

    typedef enum logic [2:0] {
        PH_IDLE, PH_INIT, PH_CHECK, PH_POLL, PH_BURST, PH_SEND, PH_HALT
    } phase_e;

    typedef enum logic [1:0] {
        SUB_IDLE, SUB_SEND, SUB_WAIT, SUB_GAP
    } sub_e;

    function automatic logic [15:0] init_addr(input logic [IDX_W-1:0] i);
        case (i)
            5'd0:    return 16'h0800;
            5'd1:    return 16'h1018;
            5'd2:    return 16'h101C;
            5'd3:    return 16'h100C;
            5'd4:    return 16'h1048;
            5'd5:    return 16'h10C0;
            5'd6:    return 16'h10C8;
            5'd7:    return 16'h8004;
            5'd8:    return 16'h1018;
            default: return 16'h0800;
        endcase
    endfunction

    function automatic logic [31:0] init_data(input logic [IDX_W-1:0] i);
        case (i)
            5'd0:    return 32'h0000_0001;
            5'd1:    return 32'h0000_0103;
            5'd2:    return 32'h0107_0302;
            5'd3:    return 32'h0001_0200;
            5'd4:    return 32'h0000_0400;
            5'd5:    return 32'h0000_0001;
            5'd6:    return 32'h0700_0000;
            5'd7:    return 32'h0000_0000;
            5'd8:    return 32'h0000_0100;
            default: return 32'h0000_00C0;
        endcase
    endfunction

    function automatic logic [15:0] chk_addr(input logic [IDX_W-1:0] i);
        case (i)
            5'd0:    return 16'h101C;
            5'd1:    return 16'h100C;
            5'd2:    return 16'h1048;
            5'd3:    return 16'h10C0;
            5'd4:    return 16'h10C8;
            5'd5:    return 16'h1018;
            default: return 16'h0800;
        endcase
    endfunction

    function automatic logic [31:0] chk_exp(input logic [IDX_W-1:0] i);
        case (i)
            5'd0:    return 32'h0107_0302;
            5'd1:    return 32'h0001_0200;
            5'd2:    return 32'h0000_0400;
            5'd3:    return 32'h0000_0001;
            5'd4:    return 32'h0700_0000;
            5'd5:    return 32'h0000_0100;
            default: return 32'h0000_00C0;
        endcase
    endfunction

    function automatic logic [31:0] chk_mask(input logic [IDX_W-1:0] i);
        return (i == 5'd6) ? 32'hFFFF_FFF0 : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] burst_word(input logic [IDX_W-1:0] i);
        return {8'h5A, 3'b000, i, ~{3'b000, i}, 8'hC3};
    endfunction

endpackage

// File: rtl/spi_bringup_engine.sv
module spi_bringup_engine #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          active;
        logic          sclk;
        logic [2:0]    bits;
        logic [CW-1:0] cnt;
        logic [7:0]    sh_tx;
        logic [7:0]    sh_rx;
        logic          done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (go) begin
            d.active = 1'b1;
            d.sclk   = 1'b0;
            d.bits   = '0;
            d.cnt    = '0;
            d.sh_tx  = tx_byte;
        end else if (q.active) begin
            if (q.cnt == CW'(HALF - 1)) begin
                d.cnt = '0;
                if (!q.sclk) begin
                    d.sclk  = 1'b1;
                    d.sh_rx = {q.sh_rx[6:0], miso};
                end else begin
                    d.sclk = 1'b0;
                    if (q.bits == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.bits  = q.bits + 3'd1;
                        d.sh_tx = {q.sh_tx[6:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk      = q.sclk;
    assign mosi      = q.sh_tx[7];
    assign byte_done = q.done;
    assign rx_byte   = q.sh_rx;
endmodule

// File: rtl/spi_bringup_rom.sv
module spi_bringup_rom
    import spi_bringup_pkg::*;
(
    input  phase_e           phase,
    input  logic [IDX_W-1:0] entry,
    input  logic [IDX_W-1:0] word_idx,
    output logic [15:0]      addr,
    output logic [7:0]       nwords,
    output logic             is_read,
    output logic [31:0]      wdata,
    output logic [31:0]      expect_word,
    output logic [31:0]      mask
);
    always_comb begin
        addr        = '0;
        nwords      = 8'd1;
        is_read     = 1'b0;
        wdata       = '0;
        expect_word = '0;
        mask        = '0;
        case (phase)
            PH_INIT: begin
                addr  = init_addr(entry);
                wdata = init_data(entry);
            end
            PH_CHECK: begin
                addr        = chk_addr(entry);
                is_read     = 1'b1;
                expect_word = chk_exp(entry);
                mask        = chk_mask(entry);
            end
            PH_POLL: begin
                addr    = ADDR_STATUS;
                is_read = 1'b1;
            end
            PH_BURST: begin
                addr   = ADDR_BURST;
                nwords = 8'(N_BURST);
                wdata  = burst_word(word_idx);
            end
            PH_SEND: begin
                addr  = ADDR_SEND;
                wdata = SEND_WORD;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_bringup_seq.sv
module spi_bringup_seq
    import spi_bringup_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int RETRY_LIMIT = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               miso,
    output logic                               sclk,
    output logic                               mosi,
    output logic                               cs_n,
    output logic                               done,
    output logic                               error,
    output logic [$clog2(RETRY_LIMIT+1)-1:0]   mismatch_cnt
);
    localparam int CNT_W   = $clog2(RETRY_LIMIT + 1);
    localparam int BIDX_W  = $clog2(4 + 4 * N_BURST);
    localparam int GAP_CYC = 2 * CLK_DIV;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    typedef struct packed {
        phase_e             phase;
        sub_e               sub;
        logic               cs_n;
        logic [BIDX_W-1:0]  bidx;
        logic [IDX_W-1:0]   entry;
        logic [GAP_W-1:0]   gap;
        logic [31:0]        rx;
        logic               fail;
        logic [CNT_W-1:0]   mcnt;
        logic               done;
        logic               error;
    } st_t;

    st_t q, d;

    logic             eng_go, eng_done;
    logic [7:0]       eng_rx, tx_byte;
    logic [15:0]      r_addr;
    logic [7:0]       r_nwords;
    logic             r_read;
    logic [31:0]      r_wdata, r_exp, r_mask;
    logic [BIDX_W-1:0] boff;
    logic [IDX_W-1:0] word_idx;
    logic [9:0]       last_idx;
    logic             last_byte;
    logic [31:0]      rx_n;
    logic             mism;

    assign boff     = q.bidx - BIDX_W'(4);
    assign word_idx = IDX_W'(boff >> 2);

    spi_bringup_rom u_rom (
        .phase       (q.phase),
        .entry       (q.entry),
        .word_idx    (word_idx),
        .addr        (r_addr),
        .nwords      (r_nwords),
        .is_read     (r_read),
        .wdata       (r_wdata),
        .expect_word (r_exp),
        .mask        (r_mask)
    );

    spi_bringup_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (eng_go),
        .tx_byte   (tx_byte),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (eng_done),
        .rx_byte   (eng_rx)
    );

    always_comb begin
        case (q.bidx)
            BIDX_W'(0): tx_byte = r_read ? OPC_READ : OPC_WRITE;
            BIDX_W'(1): tx_byte = r_addr[15:8];
            BIDX_W'(2): tx_byte = r_addr[7:0];
            BIDX_W'(3): tx_byte = r_nwords;
            default: begin
                if (r_read) tx_byte = FILL_BYTE;
                else begin
                    case (q.bidx[1:0])
                        2'd0:    tx_byte = r_wdata[31:24];
                        2'd1:    tx_byte = r_wdata[23:16];
                        2'd2:    tx_byte = r_wdata[15:8];
                        default: tx_byte = r_wdata[7:0];
                    endcase
                end
            end
        endcase
    end

    assign last_idx  = {r_nwords, 2'b00} + 10'd3;
    assign last_byte = ({{(10 - BIDX_W){1'b0}}, q.bidx} == last_idx);
    assign rx_n      = {q.rx[23:0], eng_rx};
    assign mism      = |((rx_n ^ r_exp) & r_mask);

    always_comb begin
        d      = q;
        eng_go = 1'b0;
        case (q.sub)
            SUB_IDLE: begin
                if (q.phase == PH_IDLE && start) begin
                    d.phase = PH_INIT;
                    d.entry = '0;
                    d.bidx  = '0;
                    d.fail  = 1'b0;
                    d.cs_n  = 1'b0;
                    d.sub   = SUB_SEND;
                end
            end
            SUB_SEND: begin
                eng_go = 1'b1;
                d.sub  = SUB_WAIT;
            end
            SUB_WAIT: begin
                if (eng_done) begin
                    if (q.bidx >= BIDX_W'(4)) d.rx = rx_n;
                    if (!last_byte) begin
                        d.bidx = q.bidx + BIDX_W'(1);
                        d.sub  = SUB_SEND;
                    end else begin
                        d.cs_n = 1'b1;
                        d.bidx = '0;
                        d.sub  = SUB_GAP;
                        d.gap  = GAP_W'(GAP_CYC);
                        case (q.phase)
                            PH_INIT: begin
                                if (q.entry == IDX_W'(N_INIT - 1)) begin
                                    d.phase = PH_CHECK;
                                    d.entry = '0;
                                    d.fail  = 1'b0;
                                end else begin
                                    d.entry = q.entry + IDX_W'(1);
                                end
                            end
                            PH_CHECK: begin
                                if (q.entry != IDX_W'(N_CHECK - 1)) begin
                                    d.entry = q.entry + IDX_W'(1);
                                    d.fail  = q.fail | mism;
                                end else if (q.fail | mism) begin
                                    d.mcnt  = q.mcnt + CNT_W'(1);
                                    d.entry = '0;
                                    d.fail  = 1'b0;
                                    if (d.mcnt == CNT_W'(RETRY_LIMIT)) begin
                                        d.error = 1'b1;
                                        d.phase = PH_HALT;
                                        d.sub   = SUB_IDLE;
                                    end
                                end else begin
                                    d.phase = PH_POLL;
                                end
                            end
                            PH_POLL: begin
                                d.entry = '0;
                                d.fail  = 1'b0;
                                d.phase = rx_n[READY_BIT] ? PH_BURST : PH_CHECK;
                            end
                            PH_BURST: d.phase = PH_SEND;
                            PH_SEND: begin
                                d.done  = 1'b1;
                                d.phase = PH_CHECK;
                                d.entry = '0;
                                d.fail  = 1'b0;
                            end
                            default: d.sub = SUB_IDLE;
                        endcase
                    end
                end
            end
            default: begin
                if (q.gap == '0) begin
                    d.cs_n = 1'b0;
                    d.sub  = SUB_SEND;
                end else begin
                    d.gap = q.gap - GAP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.sub   <= SUB_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n         = q.cs_n;
    assign done         = q.done;
    assign error        = q.error;
    assign mismatch_cnt = q.mcnt;
endmodule

// File: rtl/spi_bringup_checks.sv
module spi_bringup_checks #(
    parameter int CLK_DIV     = 4,
    parameter int RETRY_LIMIT = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             sclk,
    input logic                             mosi,
    input logic                             cs_n,
    input logic                             done,
    input logic                             error,
    input logic [$clog2(RETRY_LIMIT+1)-1:0] mismatch_cnt
);
    localparam int GAP_MIN = 2 * CLK_DIV;
    localparam int HW      = $clog2(GAP_MIN + 2) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hi_cnt <= '1;
        else if (!cs_n)             hi_cnt <= '0;
        else if (hi_cnt != '1)      hi_cnt <= hi_cnt + HW'(1);
    end

    initial assert_div_param_R2: assert (CLK_DIV >= 4);

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= HW'(GAP_MIN)));

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_cnt != $past(mismatch_cnt)) |-> (mismatch_cnt == $past(mismatch_cnt) + 1'b1));

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_cnt <= ($clog2(RETRY_LIMIT+1))'(RETRY_LIMIT));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> cs_n);
endmodule

bind spi_bringup_seq spi_bringup_checks #(
    .CLK_DIV     (CLK_DIV),
    .RETRY_LIMIT (RETRY_LIMIT)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .mosi         (mosi),
    .cs_n         (cs_n),
    .done         (done),
    .error        (error),
    .mismatch_cnt (mismatch_cnt)
);

// File: tb/spi_bringup_seq_bench.sv
`timescale 1ns/1ps
module spi_bringup_seq_bench;
    import spi_bringup_pkg::*;

    localparam int DIV   = 4;
    localparam int LIMIT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic sclk, mosi, cs_n, done, error;
    logic [$clog2(LIMIT+1)-1:0] mismatch_cnt;

    always #2.5 clk = ~clk;

    spi_bringup_seq #(.CLK_DIV(DIV), .RETRY_LIMIT(LIMIT)) u_spi_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .done(done), .error(error), .mismatch_cnt(mismatch_cnt)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // slave model state
    logic [31:0] regs [logic [15:0]];
    logic        ready = 1'b0;
    logic [15:0] corrupt_addr = 16'h0000;
    logic [31:0] corrupt_bits = 32'h0;
    logic [7:0]  byte_q [$];
    logic [7:0]  sh_in, cur_out;
    int          bitcnt;
    logic        cap_read;
    logic [31:0] rd_val;

    // reference model state
    int ref_phase = 0; // 0 idle 1 init 2 check 3 poll 4 burst 5 send 6 halt
    int ref_idx = 0;
    bit ref_fail = 0;
    int e_cnt = 0;
    bit e_done = 0, e_err = 0;
    bit started = 0;
    int n_txn = 0, n_poll = 0, n_send = 0, hi_cnt = 0, hr = 0, cycles = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    function automatic logic [31:0] read_value(input logic [15:0] a);
        logic [31:0] v;
        if (a == ADDR_STATUS) v = {31'b0, ready};
        else if (regs.exists(a)) v = regs[a];
        else v = 32'h0;
        if (a == corrupt_addr) v = v ^ corrupt_bits;
        return v;
    endfunction

    function automatic logic [7:0] out_byte(input int k);
        if (k < 4 || !cap_read || k > 7) return 8'h00;
        return rd_val[31 - 8*(k-4) -: 8];
    endfunction

    always @(negedge cs_n) begin
        if (!started) chk(0, "R1 cs before start", 32'(cs_n), 32'h1);
        if (ref_phase == 6) chk(0, "R11 cs after halt", 32'(cs_n), 32'h1);
        if (n_txn > 0) chk(hi_cnt >= 2*DIV, "R5 gap", 32'(hi_cnt), 32'(2*DIV));
        byte_q.delete();
        bitcnt = 0;
        cap_read = 0;
        cur_out = 8'h00;
        miso = 1'b0;
    end

    always @(posedge sclk) if (!cs_n) begin
        sh_in = {sh_in[6:0], mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) byte_q.push_back(sh_in);
        if (bitcnt == 32) begin
            cap_read = (byte_q[0] == OPC_READ);
            rd_val = read_value({byte_q[1], byte_q[2]});
        end
    end

    always @(negedge sclk) if (!cs_n) begin
        if (bitcnt % 8 == 0) cur_out = out_byte(bitcnt / 8);
        miso = cur_out[7 - (bitcnt % 8)];
    end

    always @(posedge cs_n) if (started) process_txn();

    task automatic process_txn();
        logic [7:0] e [$];
        logic [15:0] a;
        logic [31:0] w, ew, em;
        int nw;
        bit rd;
        string tag;
        n_txn++;
        chk(bitcnt % 8 == 0, "R5 whole bytes", 32'(bitcnt), 32'(8*(bitcnt/8)));
        case (ref_phase)
            1: begin a = init_addr(5'(ref_idx)); nw = 1; rd = 0; tag = "R6 init"; end
            2: begin a = chk_addr(5'(ref_idx)); nw = 1; rd = 1; tag = "R8 check"; end
            3: begin a = 16'h10C4; nw = 1; rd = 1; tag = "R9 poll"; end
            4: begin a = 16'h8800; nw = 18; rd = 0; tag = "R10 burst"; end
            default: begin a = 16'h10D0; nw = 1; rd = 0; tag = "R10 send"; end
        endcase
        e.push_back(rd ? 8'h41 : 8'h61);
        e.push_back(a[15:8]);
        e.push_back(a[7:0]);
        e.push_back(8'(nw));
        for (int i = 0; i < nw; i++) begin
            case (ref_phase)
                1: w = init_data(5'(ref_idx));
                4: w = {8'h5A, 8'(i), ~8'(i), 8'hC3};
                default: w = 32'h1;
            endcase
            for (int b = 0; b < 4; b++) e.push_back(rd ? 8'hFF : w[31 - 8*b -: 8]);
        end
        chk(byte_q.size() == e.size(), {tag, " R3 length"}, 32'(byte_q.size()), 32'(e.size()));
        for (int i = 0; i < e.size() && i < byte_q.size(); i++)
            chk(byte_q[i] == e[i], (i < 4) ? {tag, " R3 header"} : (rd ? {tag, " R4 fill"} : {tag, " R3 data"}),
                32'(byte_q[i]), 32'(e[i]));
        // apply writes to slave registers
        if (byte_q.size() >= 8 && byte_q[0] == 8'h61) begin
            a = {byte_q[1], byte_q[2]};
            for (int i = 0; i < int'(byte_q[3]) && 4 + 4*i + 3 < byte_q.size(); i++)
                regs[a + 16'(4*i)] = {byte_q[4+4*i], byte_q[5+4*i], byte_q[6+4*i], byte_q[7+4*i]};
        end
        // advance reference
        case (ref_phase)
            1: begin
                ref_idx++;
                if (ref_idx == N_INIT) begin ref_phase = 2; ref_idx = 0; ref_fail = 0; end
            end
            2: begin
                ew = chk_exp(5'(ref_idx));
                em = (chk_addr(5'(ref_idx)) == 16'h0800) ? 32'hFFFF_FFF0 : 32'hFFFF_FFFF;
                if (((rd_val ^ ew) & em) != 0) ref_fail = 1;
                ref_idx++;
                if (ref_idx == N_CHECK) begin
                    ref_idx = 0;
                    if (ref_fail) begin
                        e_cnt++;
                        ref_fail = 0;
                        if (e_cnt == LIMIT) begin e_err = 1; ref_phase = 6; end
                    end else ref_phase = 3;
                end
            end
            3: begin
                n_poll++;
                ref_phase = rd_val[0] ? 4 : 2;
                ref_idx = 0;
            end
            4: ref_phase = 5;
            default: begin
                n_send++;
                e_done = 1;
                ref_phase = 2;
                ref_idx = 0;
            end
        endcase
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(done == e_done, "R10 done flag", 32'(done), 32'(e_done));
            chk(error == e_err, "R11 error flag", 32'(error), 32'(e_err));
            chk(int'(mismatch_cnt) == e_cnt, "R8 mismatch_cnt", 32'(mismatch_cnt), 32'(e_cnt));
            if (cs_n) chk(!sclk, "R2 sclk idle", 32'(sclk), 32'h0);
            if (sclk && prev_sclk) chk(mosi == prev_mosi, "R2 mosi hold", 32'(mosi), 32'(prev_mosi));
            if (sclk) hr++;
            else if (hr != 0) begin
                chk(hr == DIV/2, "R2 sclk high time", 32'(hr), 32'(DIV/2));
                hr = 0;
            end
        end
        if (cs_n) hi_cnt++; else hi_cnt = 0;
        prev_sclk = sclk;
        prev_mosi = mosi;
        if (cycles == 190000 && !finished) begin
            finished = 1;
            chk(0, "watchdog", 32'(cycles), 32'h0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n reset", 32'(cs_n), 32'h1);
        chk(sclk == 1'b0, "R1 sclk reset", 32'(sclk), 32'h0);
        chk(done == 1'b0 && error == 1'b0, "R1 flags reset", {30'b0, done, error}, 32'h0);
        chk(mismatch_cnt == 0, "R1 counter reset", 32'(mismatch_cnt), 32'h0);
        @(negedge clk) rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk(n_txn == 0 && cs_n, "R1 quiet before start", 32'(n_txn), 32'h0);
        started = 1;
        ref_phase = 1;
        ref_idx = 0;
        pulse_start();
        // R12 extra start pulse during init
        wait (n_txn >= 3);
        pulse_start();
        // R9 not ready: loops back to readback
        wait (n_poll >= 2);
        chk(n_send == 0 && !done, "R9 no burst while busy", 32'(n_send), 32'h0);
        @(negedge clk) ready = 1'b1;
        wait (n_send >= 1);
        repeat (2) @(negedge clk);
        chk(done == 1'b1, "R10 done after send", 32'(done), 32'h1);
        // R7 masked-out bits are ignored
        @(negedge clk) begin corrupt_addr = 16'h0800; corrupt_bits = 32'h0000_0005; end
        wait (n_send >= 2);
        repeat (2) @(negedge clk);
        chk(mismatch_cnt == 0, "R7 masked bits ignored", 32'(mismatch_cnt), 32'h0);
        // R8 / R11 compared bit forces retries until the limit
        @(negedge clk) begin corrupt_addr = 16'h101C; corrupt_bits = 32'h0000_0100; end
        wait (error == 1'b1 || cycles > 180000);
        repeat (2) @(negedge clk);
        chk(error == 1'b1, "R11 error at limit", 32'(error), 32'h1);
        chk(int'(mismatch_cnt) == LIMIT, "R11 count at limit", 32'(mismatch_cnt), 32'(LIMIT));
        snap = n_txn;
        pulse_start();
        repeat (600) @(negedge clk);
        chk(n_txn == snap && cs_n, "R11 halted, start ignored", 32'(n_txn), 32'(snap));
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule